// File: doc/BRIEF.md
# Buffered Serial Transmitter with Status Flags

This block serializes bytes onto an asynchronous serial line. A one-byte holding register sits in front of the shift register. Software can queue the next byte while the current frame is still going out, and back-to-back frames then leave the line with no gap. Pacing comes from a bit-tick input that pulses once per bit period. Baud-rate generation is outside the block.

A small register bus gives access to three locations: a control/status register, a write-only data register and an interrupt-select register. The control/status register holds the enable bit and the parity configuration. It also returns two read-only flags. The holding-empty flag clears when the data register is written. The transmission-complete flag clears when the control/status register is read. The interrupt output follows whichever flag the select register picks.

Top module: `utx_top`

## Requirements
- R1: After reset the control/status register reads 0x00, the select register reads 0x00, the serial line is high and the interrupt is low.
- R2: A frame is one low start bit, then 8 data bits least significant first, then an optional parity bit, then one high stop bit. The line changes only in the cycle after a bit-tick pulse.
- R3: Control bit 1 enables the parity bit and control bit 2 selects its type. With type 0 (even), the parity bit is the XOR of the data bits. With type 1 (odd), it is the inverse of that XOR.
- R4: While control bit 0 (enable) is 0, the line stays high and no byte leaves the holding register. Clearing enable in the middle of a frame drops the frame, and the line is high two clock edges later.
- R5: Control bit 4 (holding empty) reads 0 from reset until the first byte moves into the shifter. It sets when a held byte moves into the shifter on a bit tick and clears whenever the data register (address 1) is written.
- R6: A second write to the data register before the held byte has moved into the shifter replaces that byte. Only the last byte written is sent.
- R7: Control bit 5 (complete) sets when a stop bit ends with no byte held. It is 0 while a frame is in progress. A read of the control/status register (address 0) returns the flag and then clears it.
- R8: If a byte is held when a stop bit ends, the start bit of the next frame begins on that same bit tick, with no idle bit between the frames.
- R9: Bit 0 of the select register (address 2) picks the interrupt source: 0 for holding empty, 1 for complete. The interrupt equals the chosen flag.
- R10: Control bits 7, 6 and 3 read 0, and writes to control bits 4 and 5 have no effect. The data register and address 3 read 0x00.
- R11: With the holding-empty source selected, the interrupt stays low after reset until a byte has been written and moved into the shifter, even while the transmitter is enabled and ticking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe (clears the complete flag when reading address 0) |
| regAddr | input | 2 | Register address: 0 control/status, 1 data, 2 interrupt select |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the addressed register (combinational) |
| bitTick | input | 1 | One-cycle pulse per bit period |
| txLine | output | 1 | Serial output, idle high |
| irq | output | 1 | Interrupt, follows the selected status flag |

## Verification
A bad frame counter or a stuck shift register shows on the serial line within one frame. It appears as a misplaced stop bit, a wrong parity bit or a shifted data pattern, so every byte value is sent under all four parity settings and compared against a frame built arithmetically. A flag that sets or clears on the wrong event shows up at the next status read or on the interrupt pin. A holding register that is lost or loaded twice shows as a wrong or missing second frame in the overwrite and back-to-back sequences. An abort that fails to release the line leaves it low two cycles after enable drops.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } txState_t;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic loadShift;
    logic sendData;
    logic sendParity;
    logic sendStop;
    logic forceIdle;
  } txStrobe_t;

  // control/status bit positions
  localparam int BIT_EN      = 0;
  localparam int BIT_PAR_EN  = 1;
  localparam int BIT_PAR_ODD = 2;
  localparam int BIT_EMPTY   = 4;
  localparam int BIT_DONE    = 5;

endpackage

// File: rtl/utx_datapath.sv
`timescale 1ns/1ps
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dataWr,
  input  logic [DATA_BITS-1:0] wrByte,
  input  logic                 parOdd,
  input  txStrobe_t            stb,
  output logic                 txLine
);

  logic [DATA_BITS-1:0] holdReg;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 txLineQ;

  // holding register: written from the bus, read when the shifter loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (dataWr) begin
      holdReg <= wrByte;
    end
  end

  // shifter, parity and line driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      txLineQ  <= 1'b1;
    end else begin
      if (stb.loadShift) begin
        shiftReg <= holdReg;
        parBit   <= (^holdReg) ^ parOdd;
        txLineQ  <= 1'b0;
      end else if (stb.sendData) begin
        txLineQ  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (stb.sendParity) begin
        txLineQ  <= parBit;
      end else if (stb.sendStop || stb.forceIdle) begin
        txLineQ  <= 1'b1;
      end
    end
  end

  assign txLine = txLineQ;

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stb) <= 1);

endmodule

// File: rtl/utx_ctrl.sv
`timescale 1ns/1ps
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int ADDR_W    = 2,
  parameter int REG_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              bitTick,
  output txStrobe_t         stb,
  output logic              dataWr,
  output logic              parOdd,
  output logic [REG_W-1:0]  regRdata,
  output logic              irq,
  output txState_t          stateOut,
  output logic              enOut,
  output logic              doneOut
);

  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(2);

  logic enReg, parEnReg, parOddReg, irqSelReg;
  logic holdFull, emptyFlag, doneFlag;
  logic ctrlWr, selWr, ctrlRd, setDone;
  txState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic unusedWdata;

  assign ctrlWr = regWrite && (regAddr == ADDR_CTRL);
  assign dataWr = regWrite && (regAddr == ADDR_DATA);
  assign selWr  = regWrite && (regAddr == ADDR_SEL);
  assign ctrlRd = regRead  && (regAddr == ADDR_CTRL);
  assign unusedWdata = ^regWdata;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      parEnReg  <= 1'b0;
      parOddReg <= 1'b0;
      irqSelReg <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enReg     <= regWdata[BIT_EN];
        parEnReg  <= regWdata[BIT_PAR_EN];
        parOddReg <= regWdata[BIT_PAR_ODD];
      end
      if (selWr) begin
        irqSelReg <= regWdata[0];
      end
    end
  end

  // frame sequencer, advanced only on bit ticks
  always_comb begin
    stb       = '0;
    stateNxt  = state;
    bitCntNxt = bitCnt;
    setDone   = 1'b0;
    if (!enReg) begin
      stb.forceIdle = 1'b1;
      stateNxt      = ST_IDLE;
      bitCntNxt     = '0;
    end else if (bitTick) begin
      case (state)
        ST_IDLE: begin
          if (holdFull) begin
            stb.loadShift = 1'b1;
            stateNxt      = ST_START;
          end
        end
        ST_START: begin
          stb.sendData = 1'b1;
          bitCntNxt    = CNT_W'(1);
          stateNxt     = ST_DATA;
        end
        ST_DATA: begin
          if (bitCnt == CNT_W'(DATA_BITS)) begin
            if (parEnReg) begin
              stb.sendParity = 1'b1;
              stateNxt       = ST_PAR;
            end else begin
              stb.sendStop = 1'b1;
              stateNxt     = ST_STOP;
            end
          end else begin
            stb.sendData = 1'b1;
            bitCntNxt    = bitCnt + CNT_W'(1);
          end
        end
        ST_PAR: begin
          stb.sendStop = 1'b1;
          stateNxt     = ST_STOP;
        end
        ST_STOP: begin
          if (holdFull) begin
            stb.loadShift = 1'b1;
            stateNxt      = ST_START;
          end else begin
            setDone  = 1'b1;
            stateNxt = ST_IDLE;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
    end
  end

  // status flags: a bus write beats a simultaneous load, a frame end beats a read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull  <= 1'b0;
      emptyFlag <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      if (dataWr) begin
        holdFull  <= 1'b1;
        emptyFlag <= 1'b0;
      end else if (stb.loadShift) begin
        holdFull  <= 1'b0;
        emptyFlag <= 1'b1;
      end
      if (setDone) begin
        doneFlag <= 1'b1;
      end else if (ctrlRd || stb.loadShift) begin
        doneFlag <= 1'b0;
      end
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdata[BIT_EN]      = enReg;
      regRdata[BIT_PAR_EN]  = parEnReg;
      regRdata[BIT_PAR_ODD] = parOddReg;
      regRdata[BIT_EMPTY]   = emptyFlag;
      regRdata[BIT_DONE]    = doneFlag;
    end else if (regAddr == ADDR_SEL) begin
      regRdata[0] = irqSelReg;
    end
  end

  assign irq      = irqSelReg ? doneFlag : emptyFlag;
  assign parOdd   = parOddReg;
  assign stateOut = state;
  assign enOut    = enReg;
  assign doneOut  = doneFlag;

  // R5
  empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> !holdFull);

  // R5
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !emptyFlag);

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd && !setDone) |=> !doneFlag);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> (state == ST_IDLE));

endmodule

// File: rtl/utx_top.sv
`timescale 1ns/1ps
module utx_top
  import utx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int ADDR_W    = 2,
  parameter int REG_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              bitTick,
  output logic              txLine,
  output logic              irq
);

  txStrobe_t stbW;
  txState_t  stateW;
  logic      dataWrW, parOddW, enW, doneW;

  utx_ctrl #(
    .DATA_BITS(DATA_BITS),
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrite (regWrite),
    .regRead  (regRead),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .bitTick  (bitTick),
    .stb      (stbW),
    .dataWr   (dataWrW),
    .parOdd   (parOddW),
    .regRdata (regRdata),
    .irq      (irq),
    .stateOut (stateW),
    .enOut    (enW),
    .doneOut  (doneW)
  );

  utx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .dataWr (dataWrW),
    .wrByte (regWdata[DATA_BITS-1:0]),
    .parOdd (parOddW),
    .stb    (stbW),
    .txLine (txLine)
  );

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateW == ST_START) |-> !txLine);

  // R2
  tick_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && enW) |=> $stable(txLine));

  // R4
  disabled_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enW) |-> txLine);

  // R7
  done_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneW |-> txLine);

endmodule

// File: tb/test_utx_top.sv
`timescale 1ns/1ps
module test_utx_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrite = 1'b0;
  logic       regRead = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       bitTick = 1'b0;
  logic       txLine;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_SEL  = 2'd2;

  always #5 clk = ~clk;

  utx_top i_utx_top (
    .clk      (clk),
    .rstN     (rstN),
    .regWrite (regWrite),
    .regRead  (regRead),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .bitTick  (bitTick),
    .txLine   (txLine),
    .irq      (irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRead = 1'b1; regAddr = a;
    #2 d = regRdata;
    @(negedge clk);
    regRead = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic collect(input int n, output logic [10:0] bits);
    bits = '1;
    for (int i = 0; i < n; i++) begin
      tick();
      bits[i] = txLine;
    end
  endtask

  function automatic logic [10:0] expFrame(input logic [7:0] d, input logic pe, input logic po);
    logic [10:0] f;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (pe) f[9] = (^d) ^ po;
    return f;
  endfunction

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [10:0] bits, b1, b2, fa;
    logic [7:0]  cv;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 line", txLine, 1);
    check("R1 irq", irq, 0);
    busRd(A_CTRL, rd); check("R1 ctrl", rd, 8'h00);
    busRd(A_SEL, rd);  check("R1 sel", rd, 8'h00);

    // R10 reserved and read-only bits; R11 no early interrupt
    busWr(A_CTRL, 8'hFF);
    busRd(A_CTRL, rd); check("R10 ctrl reserved", rd, 8'h07);
    busRd(A_DATA, rd); check("R10 data reads 0", rd, 8'h00);
    busRd(2'd3, rd);   check("R10 addr3 reads 0", rd, 8'h00);
    for (int i = 0; i < 4; i++) tick();
    check("R11 irq before first byte", irq, 0);
    check("R11 line idle", txLine, 1);

    // R4 disabled: byte held, not sent
    busWr(A_CTRL, 8'h00);
    busWr(A_DATA, 8'h55);
    for (int i = 0; i < 5; i++) tick();
    check("R4 line high disabled", txLine, 1);
    busRd(A_CTRL, rd); check("R4 not loaded", rd, 8'h00);
    busWr(A_CTRL, 8'h01);
    collect(10, bits);
    check("R4 held byte sent", bits, expFrame(8'h55, 1'b0, 1'b0));
    check("R9 irq on empty", irq, 1);
    tick();
    busRd(A_CTRL, rd); check("R7 done set", rd, 8'h31);
    busRd(A_CTRL, rd); check("R7 done cleared by read", rd, 8'h11);

    // R2 R3 R5 R7 sweep: every byte under every parity setting
    for (int cfg = 0; cfg < 4; cfg++) begin
      cv = {5'b0, cfg[1], cfg[0], 1'b1};
      busWr(A_CTRL, cv);
      for (int d = 0; d < 256; d++) begin
        busWr(A_DATA, 8'(d));
        busRd(A_CTRL, rd); check("R5 empty cleared by write", rd, cv);
        collect(cfg[0] ? 11 : 10, bits);
        check("R2 R3 frame", bits, expFrame(8'(d), cfg[0], cfg[1]));
        tick();
        busRd(A_CTRL, rd); check("R7 R5 flags after frame", rd, cv | 8'h30);
      end
    end

    // R6 overwrite of held byte
    busWr(A_CTRL, 8'h01);
    busWr(A_DATA, 8'hA5);
    busWr(A_DATA, 8'h3C);
    collect(10, bits);
    check("R6 last byte wins", bits, expFrame(8'h3C, 1'b0, 1'b0));
    tick();
    busRd(A_CTRL, rd); check("R6 flags", rd, 8'h31);

    // R8 back-to-back frames
    busWr(A_DATA, 8'hC3);
    collect(1, b1);
    busWr(A_DATA, 8'h96);
    busRd(A_CTRL, rd); check("R8 second byte held", rd, 8'h01);
    collect(9, b2);
    fa = '1;
    fa[0] = b1[0];
    fa[9:1] = b2[8:0];
    check("R8 first frame", fa, expFrame(8'hC3, 1'b0, 1'b0));
    collect(10, bits);
    check("R8 second frame no gap", bits, expFrame(8'h96, 1'b0, 1'b0));
    tick();
    busRd(A_CTRL, rd); check("R8 R7 done after pair", rd, 8'h31);

    // R4 abort mid-frame
    busWr(A_DATA, 8'h00);
    tick();
    tick();
    check("R4 mid-frame low", txLine, 0);
    busWr(A_CTRL, 8'h00);
    @(negedge clk);
    check("R4 abort releases line", txLine, 1);
    busRd(A_CTRL, rd); check("R4 abort flags", rd, 8'h10);
    busWr(A_CTRL, 8'h01);
    tick();
    check("R4 idle after abort", txLine, 1);
    busRd(A_CTRL, rd); check("R4 no done after abort", rd, 8'h11);

    // R9 interrupt source select
    busWr(A_SEL, 8'h01);
    busRd(A_SEL, rd); check("R9 sel readback", rd, 8'h01);
    check("R9 irq follows done low", irq, 0);
    busWr(A_DATA, 8'h81);
    collect(10, bits);
    check("R9 frame", bits, expFrame(8'h81, 1'b0, 1'b0));
    check("R9 irq low before frame end", irq, 0);
    tick();
    check("R9 irq on done", irq, 1);
    busRd(A_CTRL, rd);
    check("R9 irq cleared by read", irq, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule